// File: doc/BRIEF.md
# Byte-Addressed Program Counter with Computed Jump

This block holds the fetch address of a processor whose program memory is addressed in bytes. Each instruction word is 16 bits wide, so every instruction starts on an even byte address. Bit 0 of the counter is therefore always zero. Each cycle the block takes one of five actions: it holds, it steps forward one word, it does a computed jump, it calls a subroutine, or it returns.

A computed jump adds the working-register value, taken as a byte count, to the low byte of the address of the next instruction. If the sum is odd, bit 0 is cleared. The bits above the low byte are not changed. Calls push the return address onto a hardware stack that holds 31 entries, and returns pop it. A return-with-literal also writes an 8-bit constant into the working register.

Together these give the classic lookup-table idiom. The caller loads an index and calls the table. The table opens with a computed jump, and each entry is a return-with-literal that hands back one byte. Such a lookup uses one stack entry. Instruction decode lies outside the block, which sees only decoded strobes.

Top module: `pc_unit`

## Requirements
- R1: While rst_ni is low, fetch_addr_o is 0, wreg_we_o is 0, and both flags are 0. The return stack is empty.
- R2: With only adv_i high, fetch_addr_o becomes the old value plus 2 (modulo 2^ADDR_W) on the next rising edge.
- R3: With add_pc_i as the selected action, the low byte of the new address is (old low byte + 2 + wreg_i) mod 256 with bit 0 cleared. Bits ADDR_W-1..8 keep their old value.
- R4: With call_i as the selected action, the block pushes fetch_addr_o + 2 and loads call_tgt_i with bit 0 cleared.
- R5: ret_i pops the most recent pushed address into fetch_addr_o. Pops return addresses in last-in first-out order.
- R6: retlw_i returns as in R5. In the cycle after that edge, wreg_we_o is 1 and wreg_wdata_o equals the lit_i that was sampled. In every other cycle, wreg_we_o is 0.
- R7: A call while 31 entries are held sets ovf_o, which stays set until reset. The stack contents stay unchanged, and the PC still loads the call target.
- R8: A return or return-with-literal on an empty stack sets unf_o, which stays set until reset. The PC loads 0. A return-with-literal still writes its literal.
- R9: When several strobes are high at once, call wins, then return (ret_i or retlw_i), then add_pc_i, then adv_i. With no strobe, fetch_addr_o holds.
- R10: fetch_addr_o bit 0 is 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Step to the next instruction word |
| add_pc_i | input | 1 | Computed jump: add wreg_i to the low PC byte |
| call_i | input | 1 | Call call_tgt_i, pushing the return address |
| call_tgt_i | input | ADDR_W | Call target byte address |
| ret_i | input | 1 | Return from subroutine |
| retlw_i | input | 1 | Return and write lit_i to the working register |
| wreg_i | input | DATA_W | Working-register value (jump offset in bytes) |
| lit_i | input | DATA_W | Literal for return-with-literal |
| fetch_addr_o | output | ADDR_W | Current fetch byte address |
| wreg_we_o | output | 1 | Working-register write strobe |
| wreg_wdata_o | output | DATA_W | Working-register write data |
| ovf_o | output | 1 | Sticky return-stack overflow |
| unf_o | output | 1 | Sticky return-stack underflow |

## Verification
A wrong stack pointer or a corrupt stack entry stays hidden until a later return. It then appears as a wrong fetch address one cycle after that return, possibly many cycles after the fault. For that reason, the overflow check fills the stack to its limit and then drains every entry, comparing each one. A bad computed-jump sum or a bad carry into the upper bits shows up one edge later on fetch_addr_o. A missing literal write shows up in the cycle after the return on wreg_we_o and wreg_wdata_o.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_SEQ,
    OP_JMP,
    OP_CALL,
    OP_POP
  } pc_op_e;
endpackage

// File: rtl/pc_next.sv
module pc_next
  import pc_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  pc_op_e            op_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] wreg_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic [ADDR_W-1:0] top_i,
  input  logic              empty_i,
  output logic [ADDR_W-1:0] seq_o,
  output logic [ADDR_W-1:0] next_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] EVEN = ~ADDR_W'(1);

  logic [7:0]        low_sum;
  logic [ADDR_W-1:0] raw;

  assign seq_o   = pc_i + STEP;
  // offset counts bytes; carry out of the low byte is dropped
  assign low_sum = seq_o[7:0] + 8'(wreg_i);

  always_comb begin
    unique case (op_i)
      OP_SEQ:  raw = seq_o;
      OP_JMP:  raw = {pc_i[ADDR_W-1:8], low_sum};
      OP_CALL: raw = tgt_i;
      OP_POP:  raw = empty_i ? '0 : top_i;
      default: raw = pc_i;
    endcase
    next_o = raw & EVEN;
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 31,
  parameter int W     = 21
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         ovf_o,
  output logic         unf_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          full;

  assign full    = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign top_o   = empty_o ? '0 : mem[cnt_q - CW'(1)];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else if (push_i) begin
      if (full) ovf_o <= 1'b1;
      else      cnt_q <= cnt_q + CW'(1);
    end else if (pop_i) begin
      if (empty_o) unf_o <= 1'b1;
      else         cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full) mem[cnt_q] <= data_i;
  end

  a_r4_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !full |=> cnt_q == $past(cnt_q) + CW'(1));
  a_r7_full_push_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full |=> cnt_q == $past(cnt_q) && ovf_o);
  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  a_r8_empty_pop_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && empty_o |=> unf_o && cnt_q == '0);
  a_r8_unf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o);
endmodule

// File: rtl/pc_unit.sv
module pc_unit
  import pc_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DEPTH  = 31,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              add_pc_i,
  input  logic              call_i,
  input  logic [ADDR_W-1:0] call_tgt_i,
  input  logic              ret_i,
  input  logic              retlw_i,
  input  logic [DATA_W-1:0] wreg_i,
  input  logic [DATA_W-1:0] lit_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              wreg_we_o,
  output logic [DATA_W-1:0] wreg_wdata_o,
  output logic              ovf_o,
  output logic              unf_o
);
  pc_op_e            op;
  logic [ADDR_W-1:0] pc_q, pc_d, seq, top;
  logic              empty;

  // fixed priority: call > return > computed jump > step
  always_comb begin
    if (call_i)                op = OP_CALL;
    else if (ret_i || retlw_i) op = OP_POP;
    else if (add_pc_i)         op = OP_JMP;
    else if (adv_i)            op = OP_SEQ;
    else                       op = OP_HOLD;
  end

  pc_next #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_next (
    .op_i    (op),
    .pc_i    (pc_q),
    .wreg_i  (wreg_i),
    .tgt_i   (call_tgt_i),
    .top_i   (top),
    .empty_i (empty),
    .seq_o   (seq),
    .next_o  (pc_d)
  );

  ret_stack #(.DEPTH(DEPTH), .W(ADDR_W)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (op == OP_CALL),
    .pop_i   (op == OP_POP),
    .data_i  (seq),
    .top_o   (top),
    .empty_o (empty),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q         <= '0;
      wreg_we_o    <= 1'b0;
      wreg_wdata_o <= '0;
    end else begin
      pc_q      <= pc_d;
      wreg_we_o <= (op == OP_POP) && retlw_i;
      if ((op == OP_POP) && retlw_i) wreg_wdata_o <= lit_i;
    end
  end

  assign fetch_addr_o = pc_q;

  a_r10_even_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_addr_o[0] == 1'b0);
  a_r2_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !add_pc_i && !call_i && !ret_i && !retlw_i
    |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(2));
  a_r3_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_pc_i && !call_i && !ret_i && !retlw_i
    |=> fetch_addr_o[ADDR_W-1:8] == $past(fetch_addr_o[ADDR_W-1:8]));
  a_r6_literal_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retlw_i && !call_i |=> wreg_we_o && wreg_wdata_o == $past(lit_i));
  a_r6_no_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retlw_i |=> !wreg_we_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !add_pc_i && !call_i && !ret_i && !retlw_i |=> $stable(fetch_addr_o));
endmodule

// File: tb/pc_unit_bench.sv
module pc_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21;
  localparam int DW = 8;
  localparam int NV = 16;

  typedef struct packed {
    logic [4:0]    ctl;   // {call, ret, retlw, add, adv}
    logic [DW-1:0] wreg;
    logic [DW-1:0] lit;
    logic [AW-1:0] tgt;
    logic [AW-1:0] expc;
    logic          we;
    logic [DW-1:0] wd;
  } vec_t;

  // R2 R3 R4 R5 R6 R9 walk, starting from reset (fetch 0)
  localparam vec_t VECS [NV] = '{
    '{5'b00001, 8'h00, 8'h00, 21'h0,    21'h2,    1'b0, 8'h00},
    '{5'b00001, 8'h00, 8'h00, 21'h0,    21'h4,    1'b0, 8'h00},
    '{5'b00010, 8'h10, 8'h00, 21'h0,    21'h16,   1'b0, 8'h00},
    '{5'b00010, 8'h05, 8'h00, 21'h0,    21'h1C,   1'b0, 8'h00},
    '{5'b10000, 8'h00, 8'h00, 21'h1235, 21'h1234, 1'b0, 8'h00},
    '{5'b00001, 8'h00, 8'h00, 21'h0,    21'h1236, 1'b0, 8'h00},
    '{5'b00010, 8'hF0, 8'h00, 21'h0,    21'h1228, 1'b0, 8'h00},
    '{5'b00100, 8'h00, 8'hA5, 21'h0,    21'h1E,   1'b1, 8'hA5},
    '{5'b00001, 8'h00, 8'h00, 21'h0,    21'h20,   1'b0, 8'h00},
    '{5'b10000, 8'h00, 8'h00, 21'h300,  21'h300,  1'b0, 8'h00},
    '{5'b10000, 8'h00, 8'h00, 21'h400,  21'h400,  1'b0, 8'h00},
    '{5'b01000, 8'h00, 8'h00, 21'h0,    21'h302,  1'b0, 8'h00},
    '{5'b01000, 8'h00, 8'h00, 21'h0,    21'h22,   1'b0, 8'h00},
    '{5'b11001, 8'h00, 8'h00, 21'h500,  21'h500,  1'b0, 8'h00},
    '{5'b00111, 8'h01, 8'h3C, 21'h0,    21'h24,   1'b1, 8'h3C},
    '{5'b00000, 8'h00, 8'h00, 21'h0,    21'h24,   1'b0, 8'h00}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic adv, add_pc, call, ret, retlw;
  logic [AW-1:0] tgt;
  logic [DW-1:0] wreg, lit;
  logic [AW-1:0] fetch;
  logic we, ovf, unf;
  logic [DW-1:0] wd;
  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] model [31];

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_unit u_pc_unit (
    .clk_i(clk), .rst_ni(rst_ni), .adv_i(adv), .add_pc_i(add_pc), .call_i(call),
    .call_tgt_i(tgt), .ret_i(ret), .retlw_i(retlw), .wreg_i(wreg), .lit_i(lit),
    .fetch_addr_o(fetch), .wreg_we_o(we), .wreg_wdata_o(wd), .ovf_o(ovf), .unf_o(unf)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic apply(logic [4:0] c, logic [DW-1:0] w, logic [DW-1:0] l, logic [AW-1:0] t);
    {call, ret, retlw, add_pc, adv} = c;
    wreg = w; lit = l; tgt = t;
    @(negedge clk);
    {call, ret, retlw, add_pc, adv} = '0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    {call, ret, retlw, add_pc, adv} = '0;
    tgt = '0; wreg = '0; lit = '0;
    @(negedge clk);
    chk("R1 fetch", 32'(fetch), 0);
    chk("R1 we", 32'(we), 0);
    chk("R1 flags", 32'({ovf, unf}), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].ctl, VECS[i].wreg, VECS[i].lit, VECS[i].tgt);
      chk($sformatf("R2/R3/R4/R5/R9 vec %0d fetch", i), 32'(fetch), 32'(VECS[i].expc));
      chk($sformatf("R6 vec %0d we", i), 32'(we), 32'(VECS[i].we));
      if (VECS[i].we) chk($sformatf("R6 vec %0d data", i), 32'(wd), 32'(VECS[i].wd));
      chk($sformatf("R10 vec %0d even", i), 32'(fetch[0]), 0);
      chk($sformatf("R7/R8 vec %0d flags", i), 32'({ovf, unf}), 0);
    end

    // R8: underflow on empty stack
    do_reset();
    apply(5'b00001, 0, 0, 0);
    apply(5'b00001, 0, 0, 0);
    apply(5'b00100, 0, 8'h77, 0);
    chk("R8 pc to zero", 32'(fetch), 0);
    chk("R8 unf set", 32'(unf), 1);
    chk("R8 literal still written", 32'({we, wd}), 32'({1'b1, 8'h77}));
    apply(5'b00001, 0, 0, 0);
    chk("R8 unf sticky", 32'(unf), 1);

    // R7: fill 31 entries, overflow, then drain LIFO
    do_reset();
    for (int i = 0; i < 31; i++) begin
      model[i] = AW'(i * 16 + 2);
      apply(5'b10000, 0, 0, AW'((i + 1) * 16 + 1));
      chk("R4 call target even", 32'(fetch), 32'((i + 1) * 16));
    end
    chk("R7 no ovf at 31", 32'(ovf), 0);
    apply(5'b10000, 0, 0, 21'h1000);
    chk("R7 ovf set", 32'(ovf), 1);
    chk("R7 pc loads target", 32'(fetch), 32'h1000);
    for (int i = 30; i >= 0; i--) begin
      apply(5'b01000, 0, 0, 0);
      chk($sformatf("R5/R7 drain %0d", i), 32'(fetch), 32'(model[i]));
    end
    chk("R7 ovf sticky", 32'(ovf), 1);
    chk("R8 no unf yet", 32'(unf), 0);
    apply(5'b01000, 0, 0, 0);
    chk("R8 unf after drain", 32'(unf), 1);

    // R2 wrap and R3 low-byte wrap
    do_reset();
    apply(5'b10000, 0, 0, '1);
    chk("R4 top target", 32'(fetch), 32'h1FFFFE);
    apply(5'b00001, 0, 0, 0);
    chk("R2 wrap", 32'(fetch), 0);
    apply(5'b00010, 8'hFF, 0, 0);
    chk("R3 odd offset cleared", 32'(fetch), 32'h0);

    // R1: asynchronous reset mid-cycle
    apply(5'b00001, 0, 0, 0);
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    chk("R1 async fetch", 32'(fetch), 0);
    chk("R1 async flags", 32'({ovf, unf, we}), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule